// File: doc/BRIEF.md
# Split-Word ECC Read Path

This block sits between a flash array and the read bus. It handles one 128-bit flash word at a time. The word is treated as two 64-bit segments, and each segment carries its own 8 check bits. Each segment gets its own single-error-correct, double-error-detect check. The corrected word is returned one clock after the read is presented.

Every segment has two sticky status flags: one for a correctable single error and one for an uncorrectable multiple error. The flags collect events over any number of reads. A status-read strobe clears them all. The block keeps no error location.

For writes, the block also derives check bits combinationally from write data. The array can then store the check bits beside the data.

Top module: `flash_ecc_rdpath`

## Requirements
- R1: `wr_chk` holds 8 check bits per segment. Segment h uses data bits `[64h+63:64h]` and check bits `[8h+7:8h]`. Codeword positions run from 1 to 71, and the power-of-two positions are reserved for check bits. Data bit i sits in the i-th non-power-of-two position, in ascending order. Check bit j (j = 0..6) is the XOR of the data bits whose position has bit j set. Check bit 7 is the XOR of all data bits and check bits 0..6.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `rd_valid` high.
- R3: A read with no bit errors returns the data unchanged and sets no flag.
- R4: A read whose segment has one flipped data bit returns the original data for that segment and sets that segment's single flag.
- R5: A read whose segment has one flipped check bit returns the data unchanged and sets that segment's single flag.
- R6: A read whose segment has two flipped bits (data or check) returns that segment's raw data. It sets that segment's multiple flag and not its single flag.
- R7: Flag layout is `err_stat[0]` lower single, `[1]` upper single, `[2]` lower multiple, `[3]` upper multiple. An error in one segment changes neither the data nor the flags of the other segment.
- R8: A set flag stays set across later reads, including clean ones, until a status read.
- R9: A `stat_rd` pulse with no read in the same cycle clears every flag by the next cycle.
- R10: When a read detects an error in the same cycle as `stat_rd`, the flag for that new error is set afterwards and all other flags are cleared.
- R11: After reset, `rsp_valid` is 0 and `err_stat` is 0.
- R12: While `rd_valid` is low, `rd_data` and `rd_chk` are ignored: `rsp_data` holds and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 128 | Data to be encoded for storage |
| wr_chk | output | 16 | Check bits for `wr_data`, 8 per segment |
| rd_valid | input | 1 | Read word presented this cycle |
| rd_data | input | 128 | Raw data read from the array |
| rd_chk | input | 16 | Stored check bits read from the array |
| rsp_valid | output | 1 | Corrected response valid |
| rsp_data | output | 128 | Corrected (or raw, on multiple error) data |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| err_stat | output | 4 | Sticky single/multiple flags per segment |

## Verification
Each wrong internal state shows up at the ports one clock after the read that exposes it:
- A wrong syndrome-to-bit mapping flips a data bit other than the one that was corrupted.
- A wrong parity term makes clean words report errors, or makes single errors read as multiple.
- A bad flag update shows up on `err_stat`, either while flags should be held or on the cycle after a status read.

The sweep injects every single-bit position and a spread of bit pairs in both segments. Any decode fault therefore shows on the very vector that triggers it.

// File: rtl/fecc_pkg.sv
package fecc_pkg;

  parameter int unsigned SEG_DW  = 64;
  parameter int unsigned NUM_SEG = 2;

  // smallest p with 2**p >= dw + p + 1
  function automatic int unsigned hpar_count(int unsigned dw);
    int unsigned n;
    n = 0;
    for (int unsigned p = 31; p > 0; p--) begin
      if ((32'd1 << p) >= dw + p + 1) n = p;
    end
    return n;
  endfunction

  localparam int unsigned SEG_PW   = hpar_count(SEG_DW);
  localparam int unsigned SEG_CW   = SEG_PW + 1;
  localparam int unsigned SEG_NPOS = SEG_DW + SEG_PW;
  localparam int unsigned WORD_W   = SEG_DW * NUM_SEG;
  localparam int unsigned CHK_W    = SEG_CW * NUM_SEG;
  localparam int unsigned STAT_W   = 2 * NUM_SEG;

  typedef logic [SEG_DW-1:0] seg_data_t;
  typedef logic [SEG_CW-1:0] seg_chk_t;
  typedef logic [SEG_PW-1:0] seg_syn_t;

  // codeword position of data bit idx (non-power-of-two slots, ascending)
  function automatic int unsigned data_pos(int unsigned idx);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    for (int unsigned p = 1; p <= SEG_NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // Hamming parity over the data bits only
  function automatic seg_syn_t hamming_par(seg_data_t d);
    seg_syn_t s;
    int unsigned pos;
    s = '0;
    for (int unsigned i = 0; i < SEG_DW; i++) begin
      pos = data_pos(i);
      for (int unsigned j = 0; j < SEG_PW; j++) begin
        s[j] = s[j] ^ (d[i] & pos[j]);
      end
    end
    return s;
  endfunction

  function automatic seg_chk_t ecc_encode(seg_data_t d);
    seg_syn_t p;
    p = hamming_par(d);
    return {^{d, p}, p};
  endfunction

  // one-hot mask of the data bit addressed by a syndrome (zero if none)
  function automatic seg_data_t flip_mask(seg_syn_t s);
    seg_data_t m;
    for (int unsigned i = 0; i < SEG_DW; i++) begin
      m[i] = (data_pos(i) == 32'(s));
    end
    return m;
  endfunction

endpackage

// File: rtl/fecc_encoder.sv
module fecc_encoder
  import fecc_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    assign chk[g*SEG_CW +: SEG_CW] = ecc_encode(data[g*SEG_DW +: SEG_DW]);
  end

endmodule

// File: rtl/fecc_seg_decode.sv
module fecc_seg_decode
  import fecc_pkg::*;
(
  input  seg_data_t raw_data,
  input  seg_chk_t  raw_chk,
  output seg_data_t cor_data,
  output logic      sgl_err,
  output logic      mul_err
);

  seg_syn_t  syn;
  logic      ovr;
  logic      syn_nz;
  logic      syn_in_range;
  seg_data_t fmask;

  always_comb begin
    syn          = hamming_par(raw_data) ^ raw_chk[SEG_PW-1:0];
    ovr          = ^{raw_data, raw_chk};
    syn_nz       = |syn;
    syn_in_range = (32'(syn) <= SEG_NPOS);
    fmask        = flip_mask(syn);
    // odd overall parity: one flip (data, check or overall bit)
    sgl_err      = ovr && syn_in_range;
    // even overall parity with nonzero syndrome, or a position that does not exist
    mul_err      = (syn_nz && !ovr) || (ovr && !syn_in_range);
    cor_data     = sgl_err ? (raw_data ^ fmask) : raw_data;
  end

endmodule

// File: rtl/fecc_status.sv
module fecc_status #(
  parameter int unsigned NSEG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEG-1:0] set_sgl,
  input  logic [NSEG-1:0] set_mul,
  input  logic            clr,
  output logic [2*NSEG-1:0] flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | {set_mul, set_sgl};
  end

endmodule

// File: rtl/flash_ecc_rdpath.sv
module flash_ecc_rdpath
  import fecc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [CHK_W-1:0]     wr_chk,
  input  logic                 rd_valid,
  input  logic [WORD_W-1:0]    rd_data,
  input  logic [CHK_W-1:0]     rd_chk,
  output logic                 rsp_valid,
  output logic [WORD_W-1:0]    rsp_data,
  input  logic                 stat_rd,
  output logic [STAT_W-1:0]    err_stat
);

  logic [WORD_W-1:0]  cor_word;
  logic [NUM_SEG-1:0] dec_sgl;
  logic [NUM_SEG-1:0] dec_mul;
  logic [NUM_SEG-1:0] ev_sgl;
  logic [NUM_SEG-1:0] ev_mul;

  fecc_encoder u_enc (
    .data (wr_data),
    .chk  (wr_chk)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_dec
    fecc_seg_decode u_dec (
      .raw_data (rd_data[g*SEG_DW +: SEG_DW]),
      .raw_chk  (rd_chk[g*SEG_CW +: SEG_CW]),
      .cor_data (cor_word[g*SEG_DW +: SEG_DW]),
      .sgl_err  (dec_sgl[g]),
      .mul_err  (dec_mul[g])
    );
  end

  // detection events count only on real reads
  assign ev_sgl = rd_valid ? dec_sgl : '0;
  assign ev_mul = rd_valid ? dec_mul : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      if (rd_valid) rsp_data <= cor_word;
    end
  end

  fecc_status #(.NSEG(NUM_SEG)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_sgl (ev_sgl),
    .set_mul (ev_mul),
    .clr     (stat_rd),
    .flags   (err_stat)
  );

endmodule

// File: rtl/fecc_rdpath_chk.sv
module fecc_rdpath_chk
  import fecc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                rd_valid,
  input logic                stat_rd,
  input logic                rsp_valid,
  input logic [WORD_W-1:0]   rsp_data,
  input logic [STAT_W-1:0]   err_stat,
  input logic [NUM_SEG-1:0]  ev_sgl,
  input logic [NUM_SEG-1:0]  ev_mul
);

  // R2
  rsp_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid);

  // R12
  rsp_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(rsp_data));

  // R8
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((err_stat & $past(err_stat)) == $past(err_stat)));

  // R9
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rd_valid) |=> (err_stat == '0));

  // R10
  new_event_survives_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sgl != '0 || ev_mul != '0) |=>
      ((err_stat & {$past(ev_mul), $past(ev_sgl)}) == {$past(ev_mul), $past(ev_sgl)}));

  // R6
  sgl_mul_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sgl & ev_mul) == '0);

endmodule

bind flash_ecc_rdpath fecc_rdpath_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_valid  (rd_valid),
  .stat_rd   (stat_rd),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .err_stat  (err_stat),
  .ev_sgl    (ev_sgl),
  .ev_mul    (ev_mul)
);

// File: tb/flash_ecc_rdpath_test.sv
`timescale 1ns/1ps
module flash_ecc_rdpath_test;
  import fecc_pkg::*;

  localparam int DW = SEG_DW;
  localparam int CW = SEG_CW;
  localparam int PB = CW - 1;
  localparam int NS = NUM_SEG;
  localparam int W  = DW * NS;
  localparam int CB = CW * NS;
  localparam int FW = 2 * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [CB-1:0] wr_chk;
  logic          rd_valid = 1'b0;
  logic [W-1:0]  rd_data = '0;
  logic [CB-1:0] rd_chk = '0;
  logic          rsp_valid;
  logic [W-1:0]  rsp_data;
  logic          stat_rd = 1'b0;
  logic [FW-1:0] err_stat;

  int vec_n = 0;
  int bad_n = 0;
  bit done = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  flash_ecc_rdpath uut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_chk(wr_chk),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .stat_rd(stat_rd), .err_stat(err_stat)
  );

  // reference check bits for one segment, built from a position-indexed codeword
  function automatic logic [CW-1:0] ref_seg_chk(logic [DW-1:0] d);
    logic [255:0]  cw;
    logic [CW-1:0] c;
    int k;
    cw = '0;
    c  = '0;
    k  = 0;
    for (int p = 1; p <= DW + PB; p++) begin
      if ($countones(p) != 1) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int j = 0; j < PB; j++) begin
      for (int p = 1; p <= DW + PB; p++) begin
        if (p[j]) c[j] = c[j] ^ cw[p];
      end
    end
    c[PB] = (^d) ^ (^c[PB-1:0]);
    return c;
  endfunction

  function automatic logic [CB-1:0] ref_chk(logic [W-1:0] d);
    logic [CB-1:0] c;
    for (int h = 0; h < NS; h++) c[h*CW +: CW] = ref_seg_chk(d[h*DW +: DW]);
    return c;
  endfunction

  function automatic logic [W-1:0] next_word();
    logic [W-1:0] r;
    for (int h = 0; h < (W + 63) / 64; h++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      r[h*64 +: 64] = rng;
    end
    return r;
  endfunction

  task automatic flip(inout logic [W-1:0] d, inout logic [CB-1:0] c, input int h, input int k);
    if (k < DW) d[h*DW + k] = ~d[h*DW + k];
    else        c[h*CW + k - DW] = ~c[h*CW + k - DW];
  endtask

  task automatic do_read(input logic [W-1:0] d, input logic [CB-1:0] c,
                         input logic [W-1:0] ed, input logic [FW-1:0] ef,
                         input bit clr, input string req);
    @(negedge clk);
    rd_data  = d;
    rd_chk   = c;
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    vec_n++;
    if (rsp_valid !== 1'b1 || rsp_data !== ed || err_stat !== ef) begin
      bad_n++;
      $display("FAIL %s: valid=%b data=%h flags=%b expected valid=1 data=%h flags=%b",
               req, rsp_valid, rsp_data, err_stat, ed, ef);
    end
    if (clr) begin
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad_n++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0]  d;
    logic [W-1:0]  dd;
    logic [CB-1:0] c;
    logic [CB-1:0] cc;
    logic [W-1:0]  hold;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    vec_n++;
    if (rsp_valid !== 1'b0 || err_stat !== '0) begin
      bad_n++;
      $display("FAIL R11: valid=%b flags=%b expected valid=0 flags=0", rsp_valid, err_stat);
    end

    // R1 encoder: walking ones and pseudo-random words
    for (int i = 0; i < W + 24; i++) begin
      wr_data = (i < W) ? (W'(1) << i) : next_word();
      #1;
      vec_n++;
      if (wr_chk !== ref_chk(wr_data)) begin
        bad_n++;
        $display("FAIL R1: data=%h chk=%h expected chk=%h", wr_data, wr_chk, ref_chk(wr_data));
      end
    end

    // R3 clean reads, R2 response timing
    for (int i = 0; i < 24; i++) begin
      d = (i == 0) ? '0 : (i == 1) ? '1 : next_word();
      do_read(d, ref_chk(d), d, '0, 1'b1, "R3/R2 clean");
    end

    // R4 R5 R7 every single-bit position in every segment
    for (int h = 0; h < NS; h++) begin
      for (int k = 0; k < DW + CW; k++) begin
        d = next_word();
        c = ref_chk(d);
        dd = d;
        cc = c;
        flip(dd, cc, h, k);
        do_read(dd, cc, d, FW'(1) << h, 1'b1, (k < DW) ? "R4/R7 data single" : "R5/R7 check single");
      end
    end

    // R6 R7 double flips in every segment
    for (int h = 0; h < NS; h++) begin
      for (int k = 0; k < DW + CW; k++) begin
        d = next_word();
        c = ref_chk(d);
        dd = d;
        cc = c;
        flip(dd, cc, h, k);
        flip(dd, cc, h, (k + 1 + (k % 5) * 7) % (DW + CW));
        do_read(dd, cc, dd, FW'(1) << (NS + h), 1'b1, "R6/R7 double");
      end
    end

    // R7 lower single with upper double in the same word
    d = next_word();
    c = ref_chk(d);
    dd = d;
    cc = c;
    flip(dd, cc, 0, 5);
    flip(dd, cc, 1, 3);
    flip(dd, cc, 1, 40);
    do_read(dd, cc, {dd[W-1:DW], d[DW-1:0]}, FW'(1) | (FW'(1) << (2*NS-1)), 1'b1, "R7 mixed segments");

    // R8 sticky across a clean read
    d = next_word();
    c = ref_chk(d);
    dd = d;
    cc = c;
    flip(dd, cc, 0, 17);
    do_read(dd, cc, d, FW'(1), 1'b0, "R8 set");
    d = next_word();
    do_read(d, ref_chk(d), d, FW'(1), 1'b0, "R8 held over clean read");

    // R9 clear with no read
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    vec_n++;
    if (err_stat !== '0) begin
      bad_n++;
      $display("FAIL R9: flags=%b expected flags=0", err_stat);
    end

    // R10 new detection in the clearing cycle
    d = next_word();
    c = ref_chk(d);
    dd = d;
    cc = c;
    flip(dd, cc, 0, 2);
    flip(dd, cc, 0, 9);
    do_read(dd, cc, dd, FW'(1) << NS, 1'b0, "R10 prior flag");
    d = next_word();
    c = ref_chk(d);
    dd = d;
    cc = c;
    flip(dd, cc, 1, 30);
    @(negedge clk);
    rd_data  = dd;
    rd_chk   = cc;
    rd_valid = 1'b1;
    stat_rd  = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    stat_rd  = 1'b0;
    vec_n++;
    if (err_stat !== (FW'(1) << 1) || rsp_data !== d) begin
      bad_n++;
      $display("FAIL R10: flags=%b data=%h expected flags=%b data=%h", err_stat, rsp_data, FW'(1) << 1, d);
    end
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;

    // R12 errored input with rd_valid low
    hold = rsp_data;
    d = next_word();
    c = ref_chk(d);
    flip(d, c, 0, 1);
    flip(d, c, 1, 2);
    flip(d, c, 1, 4);
    @(negedge clk);
    rd_data = d;
    rd_chk  = c;
    @(negedge clk);
    vec_n++;
    if (rsp_valid !== 1'b0 || rsp_data !== hold || err_stat !== '0) begin
      bad_n++;
      $display("FAIL R12: valid=%b data=%h flags=%b expected valid=0 data=%h flags=0",
               rsp_valid, rsp_data, err_stat, hold);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule